// File: doc/BRIEF.md
# Multiplexed Digit Scanner with PWM Intensity

This block drives the common-cathode digit lines of a multiplexed LED display. It gives each digit slot in turn a fixed number of multiplex-clock cycles, starting from digit 0 and climbing to a programmable last digit, then wraps back to digit 0. The active digit's drive line is pulled low for its whole slot. The current digit index is also brought out so that a key scanner can share the same timing.

Inside each slot, a segment-enable strobe provides 16-step pulse-width brightness. The strobe is high for a fraction of the slot set by a 4-bit intensity code. That code comes either from one global nibble shared by all digits or from a per-digit nibble, chosen by a mode input. The final sixteenth of every slot is always dark, so a blanking gap separates adjacent digits.

A shutdown input turns off every digit drive and the strobe. It also parks the sequence at the start of digit 0.

Top module: `digit_mux_pwm`

## Requirements
- R1: With scan-limit input L, the block visits digit indices 0, 1, ..., L in ascending order, one slot each. After slot L it wraps to digit 0.
- R2: Each slot lasts SLOT_CYCLES clock cycles. During the slot, `dig_n` bit k is low only for the active digit k, all other bits are high, and `dig_idx` equals k.
- R3: For intensity code n, `seg_en` is high for the first min(n+1,15) * SLOT_CYCLES/16 cycles of the slot and low for the rest of it.
- R4: The last SLOT_CYCLES/16 cycles of every slot have `seg_en` low for every code. Codes 14 and 15 therefore both give 15/16 duty.
- R5: When `int_mode` is 0, `glob_int` sets the code for every digit and `dig_int` has no effect.
- R6: When `int_mode` is 1, digit k uses `dig_int[4k+3:4k]` as its code, and `glob_int` has no effect.
- R7: A change of `scan_limit` during a scan takes effect only when the sequence next wraps to digit 0. While `shutdown` is high, the limit is sampled on every cycle.
- R8: While `shutdown` is high, all `dig_n` bits are high, `seg_en` is low, and the sequence is held at the first cycle of digit 0. Releasing `shutdown` starts the slot of digit 0.
- R9: During and right after reset, `dig_idx` is 0 and the sequence starts from the first cycle of digit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Multiplex clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Blank the display and hold the sequence |
| scan_limit | input | IDX_W (3) | Index of the last scanned digit |
| int_mode | input | 1 | 0: global intensity, 1: per-digit intensity |
| glob_int | input | 4 | Global intensity code |
| dig_int | input | 4*NUM_DIGITS (32) | Per-digit intensity codes, digit k in bits 4k+3:4k |
| dig_n | output | NUM_DIGITS (8) | Active-low digit drives |
| seg_en | output | 1 | Segment enable strobe (PWM) |
| dig_idx | output | IDX_W (3) | Current digit index |

## Verification
The assertions check the following on every cycle:
- the slot counter stays in range and restarts after each slot end;
- the digit index never passes the latched limit and changes only at a slot end;
- the latched limit is stable except at a wrap or during shutdown;
- the strobe is low in the final sixteenth of each slot and high in its first cycle;
- shutdown darkens all outputs.

Only the bench scenarios can show that the exact on-time per digit matches each code, including the cap at codes 14 and 15. The same applies to choosing the right nibble in each mode while the other source is ignored, and to applying a limit change made in the middle of a scan only after the next wrap.

// File: rtl/digit_mux_pkg.sv
package digit_mux_pkg;
  typedef logic [3:0] nib_t;

  // number of lit sixteenths for an intensity code; capped at 15
  function automatic logic [4:0] duty_steps(input nib_t code);
    logic [4:0] n;
    n = {1'b0, code} + 5'd1;
    if (n > 5'd15) n = 5'd15;
    return n;
  endfunction
endpackage

// File: rtl/dmx_slot_timer.sv
module dmx_slot_timer #(
  parameter int SLOT_CYCLES = 800,
  localparam int CYC_W = $clog2(SLOT_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  output logic [CYC_W-1:0] cyc,
  output logic             slot_end,
  output logic             last_step
);
  localparam int STEP = SLOT_CYCLES / 16;
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(SLOT_CYCLES - 1);
  localparam logic [CYC_W-1:0] GAP_START = CYC_W'(SLOT_CYCLES - STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (hold)     cyc <= '0;
    else if (slot_end) cyc <= '0;
    else               cyc <= cyc + 1'b1;
  end

  assign slot_end  = (cyc == LAST_CYC);
  assign last_step = (cyc >= GAP_START);

  a_r2_cyc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cyc <= LAST_CYC);
  a_r2_slot_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (cyc == '0));
endmodule

// File: rtl/dmx_sequencer.sv
module dmx_sequencer #(
  parameter int NUM_DIGITS = 8,
  localparam int IDX_W = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             slot_end,
  input  logic [IDX_W-1:0] scan_limit,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] lim_q,
  output logic             wrap
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_DIGITS - 1);

  logic [IDX_W-1:0] lim_clamped;
  assign lim_clamped = (scan_limit > MAX_IDX) ? MAX_IDX : scan_limit;
  assign wrap = slot_end && (idx == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      lim_q <= '0;
    end else if (hold) begin
      idx   <= '0;
      lim_q <= lim_clamped;
    end else if (slot_end) begin
      if (wrap) begin
        idx   <= '0;
        lim_q <= lim_clamped;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  a_r1_idx_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= lim_q);
  a_r2_idx_steady_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_end && !hold) |=> $stable(idx));
  a_r7_limit_held_mid_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !hold) |=> $stable(lim_q));
endmodule

// File: rtl/dmx_pwm_gate.sv
module dmx_pwm_gate
  import digit_mux_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int SLOT_CYCLES = 800,
  localparam int IDX_W = $clog2(NUM_DIGITS),
  localparam int CYC_W = $clog2(SLOT_CYCLES)
) (
  input  logic                    hold,
  input  logic [CYC_W-1:0]        cyc,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    int_mode,
  input  nib_t                    glob_int,
  input  logic [4*NUM_DIGITS-1:0] dig_int,
  output nib_t                    code,
  output logic                    seg_en
);
  localparam int STEP = SLOT_CYCLES / 16;

  logic [CYC_W:0] on_cycles;

  assign code      = int_mode ? dig_int[idx*4 +: 4] : glob_int;
  assign on_cycles = (CYC_W+1)'(int'(duty_steps(code)) * STEP);
  assign seg_en    = !hold && ({1'b0, cyc} < on_cycles);
endmodule

// File: rtl/digit_mux_pwm.sv
module digit_mux_pwm
  import digit_mux_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int SLOT_CYCLES = 800,
  localparam int IDX_W = $clog2(NUM_DIGITS),
  localparam int CYC_W = $clog2(SLOT_CYCLES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shutdown,
  input  logic [IDX_W-1:0]        scan_limit,
  input  logic                    int_mode,
  input  logic [3:0]              glob_int,
  input  logic [4*NUM_DIGITS-1:0] dig_int,
  output logic [NUM_DIGITS-1:0]   dig_n,
  output logic                    seg_en,
  output logic [IDX_W-1:0]        dig_idx
);
  logic [CYC_W-1:0] cyc;
  logic             slot_end;
  logic             last_step;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lim_q;
  logic             wrap;
  nib_t             code;

  dmx_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(shutdown),
    .cyc(cyc), .slot_end(slot_end), .last_step(last_step)
  );

  dmx_sequencer #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .hold(shutdown), .slot_end(slot_end),
    .scan_limit(scan_limit), .idx(idx), .lim_q(lim_q), .wrap(wrap)
  );

  dmx_pwm_gate #(.NUM_DIGITS(NUM_DIGITS), .SLOT_CYCLES(SLOT_CYCLES)) u_pwm (
    .hold(shutdown), .cyc(cyc), .idx(idx), .int_mode(int_mode),
    .glob_int(glob_int), .dig_int(dig_int), .code(code), .seg_en(seg_en)
  );

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_drive
    assign dig_n[k] = !(!shutdown && (idx == IDX_W'(k)));
  end

  assign dig_idx = idx;

  a_r4_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |-> !seg_en);
  a_r3_slot_opens_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == '0 && !shutdown) |-> seg_en);
  a_r8_shutdown_dark: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (&dig_n && !seg_en));
  a_r8_parked_after_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (idx == '0 && cyc == '0));
endmodule

// File: tb/test_digit_mux_pwm.sv
module test_digit_mux_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 8;
  localparam int SLOT = 32;
  localparam int STEP = SLOT / 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shutdown = 1'b1;
  logic [2:0]  scan_limit = 3'd7;
  logic        int_mode = 1'b0;
  logic [3:0]  glob_int = 4'd0;
  logic [31:0] dig_int = 32'd0;
  logic [7:0]  dig_n;
  logic        seg_en;
  logic [2:0]  dig_idx;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  digit_mux_pwm #(.NUM_DIGITS(ND), .SLOT_CYCLES(SLOT)) i_digit_mux_pwm (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .scan_limit(scan_limit),
    .int_mode(int_mode), .glob_int(glob_int), .dig_int(dig_int),
    .dig_n(dig_n), .seg_en(seg_en), .dig_idx(dig_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {mode[39], glob[38:35], per-digit[34:3], limit[2:0]}
  localparam logic [39:0] VEC [5] = '{
    {1'b0, 4'h0, 32'hAAAA_AAAA, 3'd7},
    {1'b0, 4'hF, 32'h0000_0000, 3'd2},
    {1'b1, 4'h3, 32'hFEDC_BA98, 3'd7},
    {1'b1, 4'hF, 32'h7654_3210, 3'd7},
    {1'b1, 4'h0, 32'h0000_000E, 3'd0}
  };

  task automatic run_vec(input logic [39:0] v);
    int lim;
    @(negedge clk);
    int_mode = v[39]; glob_int = v[38:35]; dig_int = v[34:3]; scan_limit = v[2:0];
    shutdown = 1'b1;
    @(negedge clk);
    shutdown = 1'b0;
    lim = int'(v[2:0]);
    for (int s = 0; s <= lim; s++) begin
      logic [3:0] c;
      int on, cnt, exp_cnt;
      bit gap_ok, drv_ok;
      c = v[39] ? v[3 + 4*s +: 4] : v[38:35];
      on = (c == 4'hF) ? 15 : int'(c) + 1;
      exp_cnt = on * STEP;
      cnt = 0; gap_ok = 1; drv_ok = 1;
      for (int k = 0; k < SLOT; k++) begin
        #1;
        if (seg_en) cnt++;
        if (k >= SLOT - STEP && seg_en) gap_ok = 0;
        if (k < cnt - 0 && !seg_en) ; // order checked by count plus gap
        if (int'(dig_idx) != s || dig_n != ~(8'b1 << s)) drv_ok = 0;
        @(negedge clk);
      end
      check(cnt == exp_cnt, v[39] ? "R3/R6 on-time" : "R3/R5 on-time", cnt, exp_cnt);
      check(gap_ok, "R4 blank gap", int'(!gap_ok), 0);
      check(drv_ok, "R2 drive/index", int'(dig_idx), s);
    end
    #1;
    check(dig_idx == 3'd0, "R1 wrap to 0", int'(dig_idx), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R9 reset state
    @(negedge clk);
    #1;
    check(dig_idx == 3'd0, "R9 reset index", int'(dig_idx), 0);
    check(dig_n == 8'hFF && !seg_en, "R9 reset dark", int'(dig_n), 255);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (VEC[i]) run_vec(VEC[i]);

    // R5: per-digit nibbles ignored in global mode (glob 5 -> 6 steps)
    @(negedge clk);
    int_mode = 1'b0; glob_int = 4'd5; dig_int = 32'hFFFF_FFFF; scan_limit = 3'd0;
    shutdown = 1'b1;
    @(negedge clk);
    shutdown = 1'b0;
    begin
      int cnt = 0;
      for (int k = 0; k < SLOT; k++) begin
        #1; if (seg_en) cnt++;
        @(negedge clk);
      end
      check(cnt == 6 * STEP, "R5 dig_int ignored", cnt, 6 * STEP);
    end

    // R7: limit change mid-scan applies at next wrap
    @(negedge clk);
    scan_limit = 3'd2; glob_int = 4'd7; shutdown = 1'b1;
    @(negedge clk);
    shutdown = 1'b0;
    begin
      int exp_seq [8] = '{2, 0, 1, 2, 3, 4, 5, 0};
      for (int t = 0; t < 10 * SLOT; t++) begin
        #1;
        if (t == SLOT + 5) scan_limit = 3'd5;
        if (t >= 2 * SLOT && (t % SLOT) == 1)
          check(int'(dig_idx) == exp_seq[t / SLOT - 2], "R7 limit latch",
                int'(dig_idx), exp_seq[t / SLOT - 2]);
        @(negedge clk);
      end
    end

    // R8: shutdown mid-slot
    repeat (SLOT + 3) @(negedge clk);
    shutdown = 1'b1;
    #1;
    check(dig_n == 8'hFF, "R8 drives off", int'(dig_n), 255);
    check(!seg_en, "R8 strobe off", int'(seg_en), 0);
    @(negedge clk);
    #1;
    check(dig_idx == 3'd0, "R8 parked at digit 0", int'(dig_idx), 0);
    @(negedge clk);
    shutdown = 1'b0;
    #1;
    check(dig_n == 8'hFE && seg_en, "R8 release starts digit 0", int'(dig_n), 254);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule